// File: doc/BRIEF.md
# Minifloat Wavelet Split Stage

This block performs one level of discrete wavelet analysis on a stream of sampled current values. Each sample is a 16-bit minifloat word. The block keeps the last four accepted samples in a history. On every second accepted sample it runs a 4-tap low-pass filter and a 4-tap high-pass filter over that history. The low-pass result is the approximation coefficient and the high-pass result is the detail coefficient. Both results are therefore already decimated by two.

One multiplier and one adder are shared by both filters. They are stepped through eight multiply-accumulate iterations: four low-pass taps first, then four high-pass taps. While that loop runs, the sample input reports not-ready. Arithmetic truncates, saturates on overflow and flushes to zero on underflow. There are no denormals, infinities or NaNs.

Top module: `wavelet_split_stage`

## Requirements
- R1: Word format: bit 15 is the sign, bits 14:11 are the exponent in excess-7, and bits 10:0 are the mantissa with an implicit leading one. A word whose exponent and mantissa are both zero is zero, whatever its sign. All other words are normal numbers. All-zero input history gives all-zero coefficients.
- R2: With x[n] as the newest sample, each output is acc = 0 followed by acc = add(acc, mul(c_k, x[n-k])) for k = 0, 1, 2, 3 in that order. Low-pass taps c_k are the package constants LP_TAPS[k]. High-pass taps are hp0 = -lp3, hp1 = lp2, hp2 = -lp1, hp3 = lp0, where negation flips bit 15.
- R3: Multiply: if either operand is zero the result is +0. Otherwise the 12-bit significands are multiplied. If the product reaches 2.0 it is shifted right by one and the exponent is incremented. The mantissa is truncated to 11 bits, and the sign is the XOR of the operand signs.
- R4: Add: a zero operand yields the other operand. Otherwise the smaller-magnitude significand is shifted right by the exponent difference and the dropped bits are lost. The significands are then added or subtracted and the result is renormalised with truncation. The sign is that of the larger magnitude. An exact cancellation gives +0.
- R5: A result exponent above 15 saturates to the largest finite magnitude with the result sign, which is exponent 15 with mantissa all ones.
- R6: A result exponent below 0 flushes the result to +0.
- R7: Counting from reset, accepted samples with an even position (1st, 3rd, ...) only enter the history. They produce no output, and in_ready stays high after them.
- R8: After an accepted sample with an odd position (2nd, 4th, ...), approx_valid and detail_valid are low for 7 cycles. Both then pulse high together for exactly one cycle, 8 clock edges after the accepting edge. The data outputs change only on that edge.
- R9: in_ready is low from the edge that accepts an odd-position sample until the cycle in which the output valids are high. Samples offered while in_ready is low are not taken and have no effect on any later coefficient.
- R10: Reset, synchronous and active low, clears the history to zero and the sample position count to zero. It leaves in_ready high, both valids low and both data outputs zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_sample | input | 16 | Minifloat sample |
| approx_valid | output | 1 | Approximation coefficient valid pulse |
| approx_data | output | 16 | Low-pass decimated coefficient |
| detail_valid | output | 1 | Detail coefficient valid pulse |
| detail_data | output | 16 | High-pass decimated coefficient |

## Verification
A wrong tap index, a mis-shifted window or a stale accumulator shows up as a wrong coefficient on the very next output pulse. It appears 8 edges after the second sample of a pair. A unit impulse followed by zeros exposes each tap constant directly, including the mirrored, sign-flipped high-pass set. A decimation index that drifts by one appears as a valid pulse after the wrong sample, and the history window then shifts by one position for every later coefficient. A busy flag that drops early lets a sample be taken mid-loop, and the next coefficient pair then differs from the bench model.

// File: rtl/wsplit_pkg.sv
// Shared minifloat format, filter constants and result packing.
// Assumes TAPS is a power of two and DECIM is at least 2.
package wsplit_pkg;
    localparam int EXP_W    = 4;
    localparam int MAN_W    = 11;
    localparam int WORD_W   = 1 + EXP_W + MAN_W;
    localparam int EXP_BIAS = 7;
    localparam int EXP_MAX  = (1 << EXP_W) - 1;
    localparam int TAPS     = 4;
    localparam int DECIM    = 2;

    typedef logic [WORD_W-1:0] mfloat_t;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } mf_fields_t;

    // Low-pass taps, k = 0 first; the high-pass set is derived from these.
    localparam mfloat_t LP_TAPS [TAPS] = '{
        16'b1_0100_00001001000,
        16'b0_0100_11001010111,
        16'b0_0110_10101100010,
        16'b0_0101_11101110100
    };

    // Builds a word from sign, unbiased-range exponent and mantissa; saturates or flushes.
    function automatic mfloat_t mf_pack(input logic s, input int e, input logic [MAN_W-1:0] m);
        mf_fields_t f;
        if (e < 0) begin
            f = '0;
        end else if (e > EXP_MAX) begin
            f.sign = s;
            f.exp  = '1;
            f.man  = '1;
        end else begin
            f.sign = s;
            f.exp  = EXP_W'(e);
            f.man  = m;
        end
        return f;
    endfunction
endpackage

// File: rtl/mf_mul.sv
// Minifloat multiplier: truncating, saturating, flush-to-zero.
// Assumes normal operands or zero; purely combinational.
module mf_mul
    import wsplit_pkg::*;
(
    input  mfloat_t op_a,
    input  mfloat_t op_b,
    output mfloat_t prod
);
    localparam int SIG_W  = MAN_W + 1;
    localparam int PROD_W = 2 * SIG_W;

    mf_fields_t          fa, fb;
    logic [PROD_W-1:0]   sig_prod;
    logic [MAN_W-1:0]    man_res;
    logic                carry;
    int                  exp_res;

    // Multiply significands, pick the normalised mantissa window and pack.
    always_comb begin
        fa       = op_a;
        fb       = op_b;
        sig_prod = PROD_W'({1'b1, fa.man}) * PROD_W'({1'b1, fb.man});
        carry    = sig_prod[PROD_W-1];
        man_res  = carry ? sig_prod[PROD_W-2 -: MAN_W] : sig_prod[PROD_W-3 -: MAN_W];
        exp_res  = int'(fa.exp) + int'(fb.exp) - EXP_BIAS + (carry ? 1 : 0);
        if ((fa.exp == '0 && fa.man == '0) || (fb.exp == '0 && fb.man == '0))
            prod = '0;
        else
            prod = mf_pack(fa.sign ^ fb.sign, exp_res, man_res);
    end
endmodule

// File: rtl/mf_add.sv
// Minifloat adder: aligns the smaller operand by truncating shift,
// adds or subtracts, renormalises; saturating and flush-to-zero.
module mf_add
    import wsplit_pkg::*;
(
    input  mfloat_t op_a,
    input  mfloat_t op_b,
    output mfloat_t sum_out
);
    localparam int SIG_W = MAN_W + 1;

    mf_fields_t         fa, fb, fbig, fsml;
    logic [SIG_W-1:0]   sig_big, sig_aln, sig_norm;
    logic [SIG_W:0]     sig_sum;
    logic               a_zero, b_zero;
    int                 shamt;
    int                 lead;

    // Order operands by magnitude, align, combine and normalise.
    always_comb begin
        fa     = op_a;
        fb     = op_b;
        a_zero = (fa.exp == '0) && (fa.man == '0);
        b_zero = (fb.exp == '0) && (fb.man == '0);
        if ({fa.exp, fa.man} >= {fb.exp, fb.man}) begin
            fbig = fa;
            fsml = fb;
        end else begin
            fbig = fb;
            fsml = fa;
        end
        sig_big  = {1'b1, fbig.man};
        shamt    = int'(fbig.exp) - int'(fsml.exp);
        sig_aln  = (shamt >= SIG_W) ? '0 : ({1'b1, fsml.man} >> shamt);
        sig_sum  = '0;
        sig_norm = '0;
        lead     = 0;
        if (a_zero) begin
            sum_out = op_b;
        end else if (b_zero) begin
            sum_out = op_a;
        end else if (fbig.sign == fsml.sign) begin
            sig_sum = {1'b0, sig_big} + {1'b0, sig_aln};
            if (sig_sum[SIG_W])
                sum_out = mf_pack(fbig.sign, int'(fbig.exp) + 1, sig_sum[SIG_W-1:1]);
            else
                sum_out = mf_pack(fbig.sign, int'(fbig.exp), sig_sum[MAN_W-1:0]);
        end else begin
            sig_sum = {1'b0, sig_big} - {1'b0, sig_aln};
            if (sig_sum == '0) begin
                sum_out = '0;
            end else begin
                for (int i = 0; i < SIG_W; i++)
                    if (sig_sum[i]) lead = SIG_W - 1 - i;
                sig_norm = sig_sum[SIG_W-1:0] << lead;
                sum_out  = mf_pack(fbig.sign, int'(fbig.exp) - lead, sig_norm[MAN_W-1:0]);
            end
        end
    end
endmodule

// File: rtl/pair_picker.sv
// Decimation index comparator: counts accepted samples modulo RATIO and
// flags the last one of each group. Index is stored and fed back.
module pair_picker
    import wsplit_pkg::*;
#(
    parameter int RATIO = DECIM
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    output logic pick
);
    localparam int IW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [IW-1:0] LAST = IW'(RATIO - 1);

    logic [IW-1:0] idx_q;

    assign pick = take && (idx_q == LAST);

    // Advance the stored sample index on every accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (take)
            idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end
endmodule

// File: rtl/wavelet_split_stage.sv
// One-level wavelet analysis stage. Keeps a TAPS-deep sample history and,
// on every DECIM-th accepted sample, steps one shared multiply-accumulate
// through the low-pass taps and then the high-pass taps.
// Assumes TAPS is a power of two; input is stalled while the loop runs.
module wavelet_split_stage
    import wsplit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_sample,
    output logic              approx_valid,
    output logic [WORD_W-1:0] approx_data,
    output logic              detail_valid,
    output logic [WORD_W-1:0] detail_data
);
    localparam int TAP_IW    = $clog2(TAPS);
    localparam int STEP_W    = TAP_IW + 1;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(2 * TAPS - 1);
    localparam logic [TAP_IW-1:0] LAST_TAP  = TAP_IW'(TAPS - 1);
    localparam mfloat_t SIGN_MASK = {1'b1, {(WORD_W-1){1'b0}}};

    mfloat_t             hp_taps  [TAPS];
    mfloat_t             hist_q   [TAPS];
    mfloat_t             window_q [TAPS];
    logic                busy_q;
    logic [STEP_W-1:0]   step_q;
    logic [TAP_IW-1:0]   tap_idx;
    logic                use_hp;
    mfloat_t             acc_q, lp_hold_q;
    mfloat_t             coef, acc_in, prod, mac_sum;
    logic                take, fire;

    // High-pass taps: mirrored low-pass set, sign flipped on even indices.
    for (genvar k = 0; k < TAPS; k++) begin : g_hp
        if (k % 2 == 0) begin : g_neg
            assign hp_taps[k] = LP_TAPS[TAPS-1-k] ^ SIGN_MASK;
        end else begin : g_pos
            assign hp_taps[k] = LP_TAPS[TAPS-1-k];
        end
    end

    assign in_ready = ~busy_q;
    assign take     = in_valid && in_ready;
    assign tap_idx  = step_q[TAP_IW-1:0];
    assign use_hp   = step_q[TAP_IW];
    assign coef     = use_hp ? hp_taps[tap_idx] : LP_TAPS[tap_idx];
    assign acc_in   = (tap_idx == '0) ? '0 : acc_q;

    pair_picker #(.RATIO(DECIM)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .pick  (fire)
    );

    mf_mul u_mul (
        .op_a (coef),
        .op_b (window_q[0]),
        .prod (prod)
    );

    mf_add u_add (
        .op_a    (acc_in),
        .op_b    (prod),
        .sum_out (mac_sum)
    );

    // Shift each accepted sample into the history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS; i++) hist_q[i] <= '0;
        end else if (take) begin
            hist_q[0] <= in_sample;
            for (int i = 1; i < TAPS; i++) hist_q[i] <= hist_q[i-1];
        end
    end

    // Working window: loaded at loop start, shifted one place per iteration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS; i++) window_q[i] <= '0;
        end else if (fire) begin
            window_q[0] <= in_sample;
            for (int i = 1; i < TAPS; i++) window_q[i] <= hist_q[i-1];
        end else if (busy_q) begin
            if (tap_idx == LAST_TAP) begin
                for (int i = 0; i < TAPS; i++) window_q[i] <= hist_q[i];
            end else begin
                for (int i = 0; i < TAPS - 1; i++) window_q[i] <= window_q[i+1];
                window_q[TAPS-1] <= '0;
            end
        end
    end

    // Loop sequencer and accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            step_q    <= '0;
            acc_q     <= '0;
            lp_hold_q <= '0;
        end else if (fire) begin
            busy_q <= 1'b1;
            step_q <= '0;
        end else if (busy_q) begin
            acc_q <= mac_sum;
            if (tap_idx == LAST_TAP && !use_hp) lp_hold_q <= mac_sum;
            if (step_q == LAST_STEP) begin
                busy_q <= 1'b0;
                step_q <= '0;
            end else begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    // Output registers: both coefficients published with a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            approx_valid <= 1'b0;
            detail_valid <= 1'b0;
            approx_data  <= '0;
            detail_data  <= '0;
        end else begin
            approx_valid <= 1'b0;
            detail_valid <= 1'b0;
            if (busy_q && step_q == LAST_STEP) begin
                approx_data  <= lp_hold_q;
                detail_data  <= mac_sum;
                approx_valid <= 1'b1;
                detail_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wavelet_split_checker.sv
// Port-level protocol checker for wavelet_split_stage; tracks its own
// sample position and loop latency from the handshake alone.
module wavelet_split_checker
    import wsplit_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              approx_valid,
    input logic [WORD_W-1:0] approx_data,
    input logic              detail_valid,
    input logic [WORD_W-1:0] detail_data
);
    localparam int PW = (DECIM > 1) ? $clog2(DECIM) : 1;
    localparam int CW = $clog2(2 * TAPS + 2) + 1;

    logic [PW-1:0] pos_q;
    logic [CW-1:0] lat_q;
    logic          acc_now, last_now;

    assign acc_now  = in_valid && in_ready;
    assign last_now = acc_now && (pos_q == PW'(DECIM - 1));

    // Independent sample position and cycles-since-pick counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            lat_q <= '0;
        end else begin
            if (acc_now) pos_q <= (pos_q == PW'(DECIM - 1)) ? '0 : pos_q + 1'b1;
            if (last_now)          lat_q <= CW'(1);
            else if (approx_valid) lat_q <= '0;
            else if (lat_q != '0)  lat_q <= lat_q + 1'b1;
        end
    end

    // R10
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (in_ready && !approx_valid && !detail_valid && approx_data == '0 && detail_data == '0));

    // R9
    busy_after_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_now |=> !in_ready);

    // R9
    ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        approx_valid |-> in_ready);

    // R8
    out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        approx_valid |-> (lat_q == CW'(2 * TAPS + 1)));

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        approx_valid |=> !approx_valid && !detail_valid);

    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !approx_valid |-> $stable(approx_data) && $stable(detail_data));

    // R7
    decim_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        detail_valid |-> (pos_q == '0));
endmodule

bind wavelet_split_stage wavelet_split_checker u_chk (.*);

// File: tb/wavelet_split_stage_test.sv
`timescale 1ns/1ps
module wavelet_split_stage_test;
    import wsplit_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic        in_ready, approx_valid, detail_valid;
    logic [15:0] approx_data, detail_data;

    int checks = 0;
    int errors = 0;
    int accepted = 0;
    logic [15:0] hist [4];
    logic [15:0] last_lo, last_hi;

    always #2.5 clk = ~clk;

    wavelet_split_stage uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sample(in_sample), .approx_valid(approx_valid), .approx_data(approx_data),
        .detail_valid(detail_valid), .detail_data(detail_data)
    );

    function automatic bit m_zero(logic [15:0] v);
        return v[14:0] == 15'd0;
    endfunction

    function automatic logic [15:0] m_pack(bit s, int e, int m);
        logic [15:0] r;
        if (e < 0) return 16'h0000;
        if (e > 15) return {s, 15'h7FFF};
        r = {s, 4'(e), 11'(m)};
        return r;
    endfunction

    function automatic logic [15:0] m_mul(logic [15:0] a, logic [15:0] b);
        longint p;
        int e;
        if (m_zero(a) || m_zero(b)) return 16'h0000;
        p = longint'(2048 + int'(a[10:0])) * longint'(2048 + int'(b[10:0]));
        e = int'(a[14:11]) + int'(b[14:11]) - 7;
        if (p >= 64'd8388608) return m_pack(a[15] ^ b[15], e + 1, int'((p >> 12) % 2048));
        return m_pack(a[15] ^ b[15], e, int'((p >> 11) % 2048));
    endfunction

    function automatic logic [15:0] m_add(logic [15:0] a, logic [15:0] b);
        logic [15:0] big, sml;
        int d, bs, ss, t, e;
        if (m_zero(a)) return b;
        if (m_zero(b)) return a;
        if (a[14:0] >= b[14:0]) begin big = a; sml = b; end
        else begin big = b; sml = a; end
        d  = int'(big[14:11]) - int'(sml[14:11]);
        bs = 2048 + int'(big[10:0]);
        ss = (d > 11) ? 0 : ((2048 + int'(sml[10:0])) >> d);
        e  = int'(big[14:11]);
        if (big[15] == sml[15]) begin
            t = bs + ss;
            if (t >= 4096) return m_pack(big[15], e + 1, (t >> 1) % 2048);
            return m_pack(big[15], e, t % 2048);
        end
        t = bs - ss;
        if (t == 0) return 16'h0000;
        while (t < 2048) begin t = t << 1; e = e - 1; end
        return m_pack(big[15], e, t % 2048);
    endfunction

    function automatic logic [15:0] hp_tap(int k);
        logic [15:0] c = LP_TAPS[3 - k];
        return (k % 2 == 0) ? (c ^ 16'h8000) : c;
    endfunction

    task automatic check(bit ok, string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Offers one sample; if it completes a pair, checks the output window.
    task automatic send(input logic [15:0] x, input bit poke, input string tag);
        logic [15:0] lo, hi;
        bit quiet;
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = x;
        @(posedge clk);
        for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = x;
        accepted++;
        @(negedge clk);
        in_valid  = 1'b0;
        in_sample = 16'($urandom);
        if (accepted % 2 == 1) begin
            check({in_ready, approx_valid, detail_valid} == 3'b100, "R7", "no output after odd-count sample",
                  {13'd0, in_ready, approx_valid, detail_valid}, 16'h0004);
            return;
        end
        lo = 16'h0000;
        hi = 16'h0000;
        for (int k = 0; k < 4; k++) begin
            lo = m_add(lo, m_mul(LP_TAPS[k], hist[k]));
            hi = m_add(hi, m_mul(hp_tap(k), hist[k]));
        end
        check(in_ready == 1'b0, "R9", "ready low during loop", {15'd0, in_ready}, 16'h0000);
        quiet = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (k < 8) quiet &= !approx_valid && !detail_valid;
            if (poke && k == 2) begin in_valid = 1'b1; in_sample = 16'h3C55; end
            if (poke && k == 6) in_valid = 1'b0;
        end
        check(quiet, "R8", "valids low before 8th edge", {15'd0, quiet}, 16'h0001);
        check({in_ready, approx_valid, detail_valid} == 3'b111, "R8", "valids and ready at 8th edge",
              {13'd0, in_ready, approx_valid, detail_valid}, 16'h0007);
        check(approx_data == lo, poke ? "R9" : "R2", {tag, " approx"}, approx_data, lo);
        check(detail_data == hi, poke ? "R9" : "R2", {tag, " detail"}, detail_data, hi);
        last_lo = approx_data;
        last_hi = detail_data;
        @(negedge clk);
        check(!approx_valid && !detail_valid, "R8", "single-cycle pulse",
              {14'd0, approx_valid, detail_valid}, 16'h0000);
    endtask

    initial begin
        #(100000 * 5);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] x;
        void'($urandom(32'd4242));
        for (int i = 0; i < 4; i++) hist[i] = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        check({in_ready, approx_valid, detail_valid} == 3'b100, "R10", "reset handshake",
              {13'd0, in_ready, approx_valid, detail_valid}, 16'h0004);
        check(approx_data == 16'h0 && detail_data == 16'h0, "R10", "reset data",
              approx_data | detail_data, 16'h0000);
        rst_n = 1'b1;

        // R2 R10: impulse after reset exposes single taps, history starts at zero
        send(16'h3800, 1'b0, "R3 impulse");
        send(16'h0000, 1'b0, "R2 impulse a");
        check(last_lo == LP_TAPS[1], "R2", "impulse lp1", last_lo, LP_TAPS[1]);
        check(last_hi == LP_TAPS[2], "R2", "impulse hp1 = lp2", last_hi, LP_TAPS[2]);
        send(16'h0000, 1'b0, "R2 impulse b");
        send(16'h0000, 1'b0, "R2 impulse b");
        check(last_lo == LP_TAPS[3], "R2", "impulse lp3", last_lo, LP_TAPS[3]);
        check(last_hi == LP_TAPS[0], "R2", "impulse hp3 = lp0", last_hi, LP_TAPS[0]);

        // R1 all-zero history
        send(16'h0000, 1'b0, "R1 zero");
        send(16'h8000, 1'b0, "R1 zero");
        check(last_lo == 16'h0 && last_hi == 16'h0, "R1", "zero history", last_lo | last_hi, 16'h0000);

        // R5 saturation through accumulation
        for (int i = 0; i < 4; i++) send(16'h7FFF, 1'b0, "R5 sat");
        check(last_lo == 16'h7FFF, "R5", "saturated approx", last_lo, 16'h7FFF);

        // R6 underflow of every product
        for (int i = 0; i < 4; i++) send(16'h0001, 1'b0, "R6 tiny");
        check(last_lo == 16'h0 && last_hi == 16'h0, "R6", "flushed outputs", last_lo | last_hi, 16'h0000);

        // R9 samples offered while busy are ignored
        send(16'h4123, 1'b1, "R9 poke");
        send(16'hC321, 1'b1, "R9 poke");

        // R3 R4 random stream mixed with pokes
        for (int n = 0; n < 240; n++) begin
            if ($urandom_range(0, 9) == 0)
                x = 16'h0000;
            else
                x = {1'($urandom_range(0, 1)), 4'($urandom_range(2, 13)), 11'($urandom_range(0, 2047))};
            send(x, $urandom_range(0, 4) == 0, "R3 R4 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule